// File: doc/BRIEF.md
# Sync-Origin Raster Timing Generator

This block produces the raster timing for a single display head. Two free-running counters, one for pixels within a line and one for lines within a frame, both take their zero at the leading edge of sync. Every boundary (end of sync, end of blanking, last active position, total) is programmed as an absolute count against that origin. From the counters the block decodes horizontal and vertical sync, a display-enable strobe with its inverse as blank, the raw pixel and line positions, and a field flag.

Interlaced scan uses a doubled vertical total plus an explicit second active window for the other field, with its own vertical sync. There is no half-line offset. Timing values arrive through a plain register write port into a shadow bank. The shadow bank is copied to the working bank only at the frame wrap, so no frame ever mixes two timing sets. The second-field window holding end 0 and start 1 marks progressive scan. Double-scan needs no logic of its own, because software doubles the vertical values before writing them.

Top module: `raster_timing_gen`

## Requirements
- R1: Out of reset both counters read 0 and the field flag is 0. At position (0,0) hsync and vsync are both asserted.
- R2: Horizontal sync is high while the pixel counter is at most the horizontal sync-end. Vertical sync is high while the line counter is at most the vertical sync-end.
- R3: Display enable on each axis begins at the count one past that axis's blank-end value. `blank_o` is always the inverse of `de_o`.
- R4: The blank-start value on each axis is the last enabled position, and display enable drops on the count after it.
- R5: The pixel counter returns to 0 after reaching horizontal total minus one. The line counter advances once per line wrap and returns to 0 after vertical total minus one.
- R6: A register write lands in a shadow copy. The working timing changes only at the cycle where both counters wrap together.
- R7: Register addresses are 0 total, 1 sync-end, 2 blank-end, 3 blank-start and 4 second-field window. Each register holds the vertical value in bits 31:16 and the horizontal value in bits 15:0. The second-field window holds its end in 31:16 and its start in 15:0. Writes to addresses 5 to 7 are dropped.
- R8: A second-field window of end 0 and start 1 selects progressive scan. In that case there is no second active window and no second vertical sync, and the field flag stays 0.
- R9: In interlaced scan, lines strictly above the window end and up to the window start are also vertically active. A second vertical sync begins at line (window end minus vertical blank-end) and lasts for vertical sync-end plus one lines.
- R10: In interlaced scan the field flag is 1 from the first line of the second vertical sync until the frame wraps, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index (R7) |
| wr_data | input | 32 | Packed vertical/horizontal value |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Blanking, inverse of de_o |
| hpos_o | output | 16 | Pixel counter, zero at sync start |
| vpos_o | output | 16 | Line counter, zero at sync start |
| field_o | output | 1 | Field flag |

## Verification
The main decode is tried with three timing sets. The first is the progressive reset default. It pins every horizontal and vertical edge, one count either side. The second set widens only the horizontal total in the middle of a frame. It separates the shadow behaviour from an immediate update, because the old wrap must still occur in that frame and the new one only in the next. The third set is interlaced, and its second window, second sync and field flag are then compared against the same set with the window rewritten to end 0 and start 1. That comparison shows the disable encoding switches off all three interlace effects together.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int CW   = 16;
    localparam int RW   = 2 * CW;
    localparam int NREG = 5;
    localparam int AW   = 3;

    typedef enum logic [AW-1:0] {
        RA_TOTAL  = 3'd0,
        RA_SYNCE  = 3'd1,
        RA_BLANKE = 3'd2,
        RA_BLANKS = 3'd3,
        RA_FIELD2 = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [RW-1:0] tot;
        logic [RW-1:0] se;
        logic [RW-1:0] be;
        logic [RW-1:0] bs;
        logic [RW-1:0] f2;
    } tset_t;
endpackage

// File: rtl/rtg_regbank.sv
module rtg_regbank
    import rtg_pkg::*;
#(
    parameter tset_t RST_SET = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [RW-1:0] wr_data,
    input  logic          load,
    output tset_t         act_o
);
    typedef struct packed {
        tset_t shd;
        tset_t act;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_TOTAL:  bank_d.shd.tot = wr_data;
                RA_SYNCE:  bank_d.shd.se  = wr_data;
                RA_BLANKE: bank_d.shd.be  = wr_data;
                RA_BLANKS: bank_d.shd.bs  = wr_data;
                RA_FIELD2: bank_d.shd.f2  = wr_data;
                default: ;
            endcase
        end
        if (load) begin
            bank_d.act = bank_q.shd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.shd <= RST_SET;
            bank_q.act <= RST_SET;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign act_o = bank_q.act;

    AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank_q.act)); // R6
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] sync_end,
    input  logic [CW-1:0] blank_end,
    input  logic [CW-1:0] blank_start,
    output logic          sync_o,
    output logic          act_o
);
    always_comb begin
        sync_o = (cnt <= sync_end);
        act_o  = (cnt > blank_end) && (cnt <= blank_start);
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter logic [RW-1:0] RST_TOTAL  = {16'd10, 16'd20},
    parameter logic [RW-1:0] RST_SYNCE  = {16'd0,  16'd1},
    parameter logic [RW-1:0] RST_BLANKE = {16'd2,  16'd4},
    parameter logic [RW-1:0] RST_BLANKS = {16'd7,  16'd15},
    parameter logic [RW-1:0] RST_FIELD2 = {16'd0,  16'd1}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [RW-1:0] wr_data,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          blank_o,
    output logic [CW-1:0] hpos_o,
    output logic [CW-1:0] vpos_o,
    output logic          field_o
);
    localparam tset_t RST_SET = '{tot: RST_TOTAL, se: RST_SYNCE, be: RST_BLANKE,
                                  bs: RST_BLANKS, f2: RST_FIELD2};
    localparam int NAXIS = 2;

    typedef struct packed {
        logic [CW-1:0] hcnt;
        logic [CW-1:0] vcnt;
        logic          field;
    } scan_t;

    scan_t scan_d, scan_q;
    tset_t act;
    logic  hend, vend, frame_end;
    logic  ilace;
    logic [CW-1:0] f2_end, f2_start, f2_origin;
    logic [CW-1:0] axis_cnt  [NAXIS];
    logic [CW-1:0] axis_se   [NAXIS];
    logic [CW-1:0] axis_be   [NAXIS];
    logic [CW-1:0] axis_bs   [NAXIS];
    logic          axis_sync [NAXIS];
    logic          axis_act  [NAXIS];
    logic          v2_act, v2_sync;
    logic [CW-1:0] v2_rel;

    rtg_regbank #(.RST_SET(RST_SET)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (frame_end),
        .act_o   (act)
    );

    // axis 0 horizontal (low half), axis 1 vertical (high half)
    assign axis_cnt[0] = scan_q.hcnt;
    assign axis_cnt[1] = scan_q.vcnt;

    generate
        for (genvar a = 0; a < NAXIS; a++) begin : g_axis
            assign axis_se[a] = act.se[a*CW +: CW];
            assign axis_be[a] = act.be[a*CW +: CW];
            assign axis_bs[a] = act.bs[a*CW +: CW];
            rtg_axis #(.CW(CW)) u_axis (
                .cnt         (axis_cnt[a]),
                .sync_end    (axis_se[a]),
                .blank_end   (axis_be[a]),
                .blank_start (axis_bs[a]),
                .sync_o      (axis_sync[a]),
                .act_o       (axis_act[a])
            );
        end
    endgenerate

    always_comb begin
        f2_end    = act.f2[RW-1:CW];
        f2_start  = act.f2[CW-1:0];
        ilace     = !((f2_end == '0) && (f2_start == CW'(1)));
        f2_origin = f2_end - axis_be[1];
        hend      = (scan_q.hcnt == act.tot[CW-1:0] - 1'b1);
        vend      = (scan_q.vcnt == act.tot[RW-1:CW] - 1'b1);
        frame_end = hend && vend;
        v2_rel    = scan_q.vcnt - f2_origin;
        v2_act    = ilace && (scan_q.vcnt > f2_end) && (scan_q.vcnt <= f2_start);
        v2_sync   = ilace && (scan_q.vcnt >= f2_origin) && (v2_rel <= axis_se[1]);
    end

    always_comb begin
        scan_d = scan_q;
        if (hend) begin
            scan_d.hcnt = '0;
            if (vend) begin
                scan_d.vcnt  = '0;
                scan_d.field = 1'b0;
            end else begin
                scan_d.vcnt = scan_q.vcnt + 1'b1;
                if (ilace && (scan_d.vcnt == f2_origin)) begin
                    scan_d.field = 1'b1;
                end
            end
        end else begin
            scan_d.hcnt = scan_q.hcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign hsync_o = axis_sync[0];
    assign vsync_o = axis_sync[1] || v2_sync;
    assign de_o    = axis_act[0] && (axis_act[1] || v2_act);
    assign blank_o = !de_o;
    assign hpos_o  = scan_q.hcnt;
    assign vpos_o  = scan_q.vcnt;
    assign field_o = scan_q.field;

    AST_ORIGIN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_q.hcnt == '0 && scan_q.vcnt == '0) |-> (hsync_o && vsync_o)); // R1
    AST_SYNC_NOT_DE: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_o |-> !de_o); // R3
    AST_HWRAP: assert property (@(posedge clk) disable iff (!rst_n)
        hend |=> (scan_q.hcnt == '0)); // R5
    AST_HSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        !hend |=> (scan_q.hcnt == $past(scan_q.hcnt) + 1'b1)); // R5
    AST_VHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hend |=> $stable(scan_q.vcnt)); // R5
    AST_FIELD_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        !ilace |-> !scan_q.field); // R8
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o, vsync_o, de_o, blank_o, field_o;
    logic [15:0] hpos_o, vpos_o;

    int checks = 0;
    int errors = 0;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .blank_o(blank_o), .hpos_o(hpos_o), .vpos_o(vpos_o), .field_o(field_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at (%0d,%0d): actual %0d expected %0d", req, hpos_o, vpos_o, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic goto(input int h, input int v);
        int n = 0;
        while (!(hpos_o == 16'(h) && vpos_o == 16'(v)) && n < 5000) begin
            step();
            n++;
        end
        if (n >= 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: position (%0d,%0d) not reached, actual (%0d,%0d) expected (%0d,%0d)",
                     h, v, hpos_o, vpos_o, h, v);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        step();
        wr_en = 1'b0;
        step();
    endtask

    task automatic t_reset();
        step();
        rst_n = 1'b1;
        chk("R1 hpos", hpos_o, 0);
        chk("R1 vpos", vpos_o, 0);
        chk("R1 field", field_o, 0);
        chk("R1 hsync", hsync_o, 1);
        chk("R1 vsync", vsync_o, 1);
        chk("R3 blank inverse", blank_o, 1);
    endtask

    // default: h tot 20 se 1 be 4 bs 15 ; v tot 10 se 0 be 2 bs 7
    task automatic t_progressive();
        goto(1, 0); chk("R2 hsync at sync-end", hsync_o, 1);
        step();     chk("R2 hsync after sync-end", hsync_o, 0);
        goto(0, 1); chk("R2 vsync after sync-end", vsync_o, 0);
        goto(4, 2); chk("R3 de at v blank-end", de_o, 0);
        goto(4, 3); chk("R3 de at h blank-end", de_o, 0);
        step();     chk("R3 de one past blank-end", de_o, 1);
                    chk("R3 blank inverse", blank_o, 0);
        goto(15, 3); chk("R4 de at h blank-start", de_o, 1);
        step();      chk("R4 de past h blank-start", de_o, 0);
        goto(5, 7);  chk("R4 de at v blank-start", de_o, 1);
        goto(5, 8);  chk("R4 de past v blank-start", de_o, 0);
        goto(19, 8); step();
        chk("R5 line wrap h", hpos_o, 0);
        chk("R5 line wrap v", vpos_o, 9);
        goto(19, 9); step();
        chk("R5 frame wrap h", hpos_o, 0);
        chk("R5 frame wrap v", vpos_o, 0);
    endtask

    task automatic t_shadow();
        goto(3, 2);
        wr(0, {16'd10, 16'd24});
        goto(19, 2); step();
        chk("R6 old total kept in frame", hpos_o, 0);
        goto(0, 0);
        goto(19, 0); step();
        chk("R6 new total after frame wrap", hpos_o, 20);
        goto(23, 0); step();
        chk("R7 horizontal half of total", hpos_o, 0);
        chk("R7 vertical half of total", vpos_o, 1);
    endtask

    // field lines 5: v se 0 be 1 bs 3 ; tot 11 ; window end 6 start 8
    task automatic t_interlace();
        goto(0, 0);
        wr(0, {16'd11, 16'd20});
        wr(1, {16'd0,  16'd1});
        wr(2, {16'd1,  16'd4});
        wr(3, {16'd3,  16'd15});
        wr(7, {16'd0,  16'd1});
        wr(4, {16'd6,  16'd8});
        goto(0, 0);
        goto(5, 1); chk("R3 interlaced field one blank", de_o, 0);
        goto(5, 2); chk("R3 interlaced field one active", de_o, 1);
                    chk("R10 field in first field", field_o, 0);
        goto(5, 3); chk("R4 field one last line", de_o, 1);
        goto(5, 4); chk("R4 field one past blank-start", de_o, 0);
        goto(0, 5); chk("R9 second vsync", vsync_o, 1);
                    chk("R10 field set", field_o, 1);
        goto(0, 6); chk("R9 second vsync ends", vsync_o, 0);
        goto(5, 6); chk("R9 window end blank", de_o, 0);
        goto(5, 7); chk("R9 window active", de_o, 1);
        goto(5, 8); chk("R9 window start active", de_o, 1);
        goto(5, 9); chk("R9 past window", de_o, 0);
                    chk("R10 field held", field_o, 1);
        goto(19, 10); step();
        chk("R5 interlaced frame wrap", vpos_o, 0);
        chk("R10 field cleared at wrap", field_o, 0);
    endtask

    task automatic t_disable();
        goto(0, 0);
        wr(4, {16'd0, 16'd1});
        goto(0, 0);
        goto(0, 5); chk("R8 no second vsync", vsync_o, 0);
                    chk("R8 field held low", field_o, 0);
        goto(5, 7); chk("R8 no second window", de_o, 0);
        goto(5, 2); chk("R8 field one still active", de_o, 1);
    endtask

    initial begin
        t_reset();
        t_progressive();
        t_shadow();
        t_interlace();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule